// File: doc/BRIEF.md
# Monotonic Wall-Clock Advance Gate

This block owns the 64-bit wall-clock register of an audio controller. Software or a sequencer asks for the clock to move to a new time. The gate checks that request against the progress of the audio streams it serves. An ordinary request is applied only when every stream marked active reports that it has already passed the requested time. When applied, the register takes the larger of the requested time and the elapsed times of the active streams, so it never falls behind a stream. A forced request skips the stream check and loads the requested time directly.

The register never moves backwards. Any request below the current value is refused, the register keeps its value, and a sticky error flag is raised. Applied updates that leave the clock where it already was are counted. A run of such stale updates raises a warning.

Requests arrive on a valid/ready channel. A request is taken on the clock edge where `req_valid` and `req_ready` are both high. The outcome appears on a single-entry response channel in the following cycle. The response stays valid and stable until `rsp_ready` is seen high. `req_ready` is high whenever the response slot is empty or is being drained in the same cycle, so a stalled consumer stalls the requester. The stream flags, the elapsed times and the force bit are sampled on the handshake edge.

Top module: `wallclk_gate`

## Requirements
- R1: After reset, `wall_clock` is 0, `rsp_valid`, `stale_warn` and `back_err` are 0, and `req_ready` is 1.
- R2: A non-forced request is applied only if every stream whose `strm_active` bit is 1 has its `strm_passed` bit at 1. Streams whose active bit is 0 have no effect on this condition. If the condition fails, the register is left unchanged.
- R3: A forced request (`req_force`=1) that is not backward loads `req_value` into the register, whatever the stream flags and elapsed times are.
- R4: An applied non-forced request loads the maximum of `req_value` and the elapsed times of the active streams. Stream i's elapsed time is `strm_elapsed[i*64 +: 64]`. Elapsed times of inactive streams are ignored.
- R5: A request, forced or not, whose `req_value` is below the current `wall_clock` is refused and leaves the register unchanged. It sets `back_err`, which stays at 1 until reset.
- R6: Each applied update whose new value equals the old value increments a saturating stale count. An applied update to a different value clears the count. Refused and held requests leave the count unchanged. `stale_warn` is 1 while the count exceeds 3, which is from the fourth consecutive equal update on.
- R7: In the cycle after a request handshake, `rsp_valid` is 1. `rsp_accepted` is 1 exactly when the register value after the request equals `req_value`, and 0 (delayed) otherwise.
- R8: `req_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid` is 1 and `rsp_ready` is 0, the response stays valid and `rsp_accepted` holds its value.
- R9: `wall_clock` changes only on the edge of a request handshake and never decreases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be taken this cycle |
| req_value | input | WCW | Requested wall-clock time |
| req_force | input | 1 | Apply without checking the streams |
| strm_active | input | NS | Stream i takes part in the passed check |
| strm_passed | input | NS | Stream i has passed the requested time |
| strm_elapsed | input | NS*WCW | Absolute elapsed time per stream, stream i at bits i*WCW upward |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_accepted | output | 1 | Register equals the requested time (1) or the request was delayed (0) |
| wall_clock | output | WCW | Current wall-clock register |
| stale_warn | output | 1 | Too many consecutive stale updates |
| back_err | output | 1 | Sticky flag: a backward request was refused |

## Verification
Directed requests cover several cases. One has an inactive stream that has not passed and carries a huge elapsed time, which separates masked streams from active ones. One has an active stream lagging, which separates a held request from an applied one. One has an active stream ahead of the request, which separates an applied-but-delayed response from an accepted one. One is forced with no stream passed. Backward requests, forced and not, show refusal and that the error flag stays set. A run of equal updates followed by a differing one probes the stale threshold at its exact count. A stalled consumer shows that requests and responses hold. A long random mix with small steps follows, where backward, equal and held requests occur often. It is compared cycle by cycle with a behavioural model.

// File: rtl/wcg_pkg.sv
package wcg_pkg;
  // outcome of one request
  typedef enum logic [1:0] {
    DEC_HOLD   = 2'd0,
    DEC_APPLY  = 2'd1,
    DEC_REFUSE = 2'd2
  } wcg_decision_e;

  typedef struct packed {
    logic accepted;
  } wcg_rsp_t;
endpackage

// File: rtl/wcg_stream_merge.sv
module wcg_stream_merge #(
  parameter int NS  = 3,
  parameter int WCW = 64
) (
  input  logic [WCW-1:0]    seed,
  input  logic [NS-1:0]     active,
  input  logic [NS-1:0]     passed,
  input  logic [NS*WCW-1:0] elapsed,
  output logic              all_passed,
  output logic [WCW-1:0]    merged
);
  logic [WCW-1:0] chain [NS+1];
  logic [NS:0]    ok_chain;

  assign chain[0]    = seed;
  assign ok_chain[0] = 1'b1;

  for (genvar i = 0; i < NS; i++) begin : g_stage
    logic [WCW-1:0] el;
    logic           bigger;
    assign el            = elapsed[i*WCW +: WCW];
    assign bigger        = active[i] && (el > chain[i]);
    assign chain[i+1]    = bigger ? el : chain[i];
    assign ok_chain[i+1] = ok_chain[i] && (passed[i] || !active[i]);
  end

  assign merged     = chain[NS];
  assign all_passed = ok_chain[NS];
endmodule

// File: rtl/wcg_stale_tracker.sv
module wcg_stale_tracker #(
  parameter int LIMIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  logic same,
  output logic warn
);
  localparam int CW = $clog2(LIMIT + 2);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  localparam logic [CW-1:0] CLIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (upd) begin
      if (!same)           cnt <= '0;
      else if (cnt != CMAX) cnt <= cnt + 1'b1;
    end
  end

  assign warn = (cnt > CLIM);
endmodule

// File: rtl/wcg_rsp_slot.sv
module wcg_rsp_slot
  import wcg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  wcg_rsp_t load_data,
  input  logic     rsp_ready,
  output logic     rsp_valid,
  output wcg_rsp_t rsp_data,
  output logic     can_take
);
  assign can_take = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_data  <= load_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/wallclk_gate.sv
module wallclk_gate
  import wcg_pkg::*;
#(
  parameter int NS          = 3,
  parameter int WCW         = 64,
  parameter int STALE_LIMIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [WCW-1:0]    req_value,
  input  logic              req_force,
  input  logic [NS-1:0]     strm_active,
  input  logic [NS-1:0]     strm_passed,
  input  logic [NS*WCW-1:0] strm_elapsed,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_accepted,
  output logic [WCW-1:0]    wall_clock,
  output logic              stale_warn,
  output logic              back_err
);
  logic           fire;
  logic           all_passed;
  logic [WCW-1:0] merged;
  logic [WCW-1:0] cand;
  logic [WCW-1:0] result;
  wcg_decision_e  dec;
  wcg_rsp_t       rsp_in, rsp_out;

  wcg_stream_merge #(.NS(NS), .WCW(WCW)) u_merge (
    .seed       (req_value),
    .active     (strm_active),
    .passed     (strm_passed),
    .elapsed    (strm_elapsed),
    .all_passed (all_passed),
    .merged     (merged)
  );

  assign fire = req_valid && req_ready;

  always_comb begin
    if (req_value < wall_clock)          dec = DEC_REFUSE;
    else if (req_force || all_passed)    dec = DEC_APPLY;
    else                                 dec = DEC_HOLD;
  end

  assign cand   = req_force ? req_value : merged;
  assign result = (dec == DEC_APPLY) ? cand : wall_clock;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wall_clock <= '0;
      back_err   <= 1'b0;
    end else if (fire) begin
      wall_clock <= result;
      if (dec == DEC_REFUSE) back_err <= 1'b1;
    end
  end

  wcg_stale_tracker #(.LIMIT(STALE_LIMIT)) u_stale (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (fire && (dec == DEC_APPLY)),
    .same  (cand == wall_clock),
    .warn  (stale_warn)
  );

  assign rsp_in.accepted = (result == req_value);

  wcg_rsp_slot u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (fire),
    .load_data (rsp_in),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_out),
    .can_take  (req_ready)
  );

  assign rsp_accepted = rsp_out.accepted;
endmodule

// File: rtl/wcg_checker.sv
module wcg_checker #(
  parameter int NS  = 3,
  parameter int WCW = 64
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic [WCW-1:0] req_value,
  input logic           req_force,
  input logic [NS-1:0]  strm_active,
  input logic [NS-1:0]  strm_passed,
  input logic           rsp_valid,
  input logic           rsp_ready,
  input logic           rsp_accepted,
  input logic [WCW-1:0] wall_clock,
  input logic           stale_warn,
  input logic           back_err
);
  logic armed;
  logic fire;
  assign fire = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_never_back_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    wall_clock >= $past(wall_clock));

  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !fire |=> $stable(wall_clock));

  assert_held_when_lagging_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (fire && !req_force && ((strm_active & ~strm_passed) != '0)) |=> $stable(wall_clock));

  assert_refuse_backward_R5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (fire && (req_value < wall_clock)) |=> ($stable(wall_clock) && back_err));

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    back_err |=> back_err);

  assert_rsp_follows_R7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    fire |=> rsp_valid);

  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_accepted)));

  assert_warn_on_fire_R6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !fire |=> $stable(stale_warn));
endmodule

bind wallclk_gate wcg_checker #(.NS(NS), .WCW(WCW)) u_wcg_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_value    (req_value),
  .req_force    (req_force),
  .strm_active  (strm_active),
  .strm_passed  (strm_passed),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_accepted (rsp_accepted),
  .wall_clock   (wall_clock),
  .stale_warn   (stale_warn),
  .back_err     (back_err)
);

// File: tb/tb_wallclk_gate.sv
module tb_wallclk_gate;
  localparam int NS = 3;
  localparam int W  = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [W-1:0]  req_value = '0;
  logic          req_force = 1'b0;
  logic [NS-1:0] strm_active = '0;
  logic [NS-1:0] strm_passed = '0;
  logic [NS*W-1:0] strm_elapsed = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic          rsp_accepted;
  logic [W-1:0]  wall_clock;
  logic          stale_warn;
  logic          back_err;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wallclk_gate #(.NS(NS), .WCW(W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_value(req_value), .req_force(req_force), .strm_active(strm_active),
    .strm_passed(strm_passed), .strm_elapsed(strm_elapsed), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_accepted(rsp_accepted), .wall_clock(wall_clock),
    .stale_warn(stale_warn), .back_err(back_err)
  );

  // behavioural reference model
  longint unsigned m_wc = 0;
  int  m_cnt = 0;
  bit  m_err = 0, m_rv = 0, m_acc = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_wc = 0; m_cnt = 0; m_err = 0; m_rv = 0; m_acc = 0;
    end else begin
      bit fire;
      fire = req_valid && (!m_rv || rsp_ready);
      if (m_rv && rsp_ready) m_rv = 0;
      if (fire) begin
        longint unsigned res, mx;
        bit allp, apply;
        res = m_wc; apply = 0;
        if (req_value < m_wc) m_err = 1;
        else begin
          allp = 1; mx = req_value;
          for (int i = 0; i < NS; i++) begin
            if (strm_active[i]) begin
              if (!strm_passed[i]) allp = 0;
              if (strm_elapsed[i*W +: W] > mx) mx = strm_elapsed[i*W +: W];
            end
          end
          if (req_force) begin res = req_value; apply = 1; end
          else if (allp) begin res = mx; apply = 1; end
        end
        if (apply) begin
          if (res == m_wc) m_cnt++; else m_cnt = 0;
          m_wc = res;
        end
        m_rv = 1;
        m_acc = (m_wc == req_value);
      end
    end
  end

  task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model on every clock, away from the edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R9 wall_clock", wall_clock, m_wc);
      chk("R8 rsp_valid", rsp_valid, m_rv);
      chk("R8 req_ready", req_ready, (!m_rv || rsp_ready));
      if (m_rv) chk("R7 rsp_accepted", rsp_accepted, m_acc);
      chk("R6 stale_warn", stale_warn, (m_cnt > 3));
      chk("R5 back_err", back_err, m_err);
    end
  end

  task automatic send(input longint unsigned v, input bit f, input logic [NS-1:0] a,
                      input logic [NS-1:0] p, input longint unsigned e0,
                      input longint unsigned e1, input longint unsigned e2);
    @(negedge clk); #1;
    req_value = v; req_force = f; strm_active = a; strm_passed = p;
    strm_elapsed = {e2[W-1:0], e1[W-1:0], e0[W-1:0]};
    req_valid = 1'b1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk); #1;
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #2;
    chk("R1 wall_clock", wall_clock, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 stale_warn", stale_warn, 0);
    chk("R1 back_err", back_err, 0);
    chk("R1 req_ready", req_ready, 1);

    // inactive stream lagging with a huge elapsed time is ignored
    send(100, 0, 3'b011, 3'b011, 50, 60, 999);
    chk("R2 applied", wall_clock, 100);
    chk("R4 inactive ignored", wall_clock, 100);
    chk("R7 accepted", rsp_accepted, 1);
    // an active stream lags: held
    send(200, 0, 3'b111, 3'b101, 0, 0, 0);
    chk("R2 held", wall_clock, 100);
    chk("R7 delayed", rsp_accepted, 0);
    // active stream ahead: max taken, reported delayed
    send(200, 0, 3'b011, 3'b011, 250, 10, 0);
    chk("R4 max", wall_clock, 250);
    chk("R7 delayed max", rsp_accepted, 0);
    // forced, nobody passed
    send(300, 1, 3'b111, 3'b000, 0, 0, 0);
    chk("R3 forced", wall_clock, 300);
    chk("R7 forced accepted", rsp_accepted, 1);
    // stale run
    for (int k = 1; k <= 4; k++) begin
      send(300, 0, 3'b000, 3'b000, 0, 0, 0);
      chk("R6 stale warn", stale_warn, (k > 3));
    end
    send(301, 0, 3'b000, 3'b000, 0, 0, 0);
    chk("R6 cleared", stale_warn, 0);
    // backward, forced
    send(150, 1, 3'b000, 3'b000, 0, 0, 0);
    chk("R5 refused", wall_clock, 301);
    chk("R5 err", back_err, 1);
    send(120, 0, 3'b000, 3'b000, 0, 0, 0);
    chk("R5 refused nf", wall_clock, 301);
    send(400, 0, 3'b000, 3'b000, 0, 0, 0);
    chk("R5 sticky", back_err, 1);
    chk("R5 later advance", wall_clock, 400);

    // back-pressure
    @(negedge clk); #1;
    rsp_ready = 1'b0;
    send(500, 0, 3'b000, 3'b000, 0, 0, 0);
    chk("R8 first taken", wall_clock, 500);
    req_value = 600; req_force = 1'b1; req_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #2;
      chk("R8 stall ready", req_ready, 0);
      chk("R8 stall valid", rsp_valid, 1);
      chk("R9 stall clock", wall_clock, 500);
    end
    rsp_ready = 1'b1;
    @(negedge clk); #1;
    req_valid = 1'b0;
    chk("R8 resumed", wall_clock, 600);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk); #1;
      req_valid = ($urandom_range(0, 3) != 0);
      rsp_ready = ($urandom_range(0, 3) != 0);
      req_force = ($urandom_range(0, 5) == 0);
      strm_active = NS'($urandom);
      strm_passed = NS'($urandom);
      begin
        longint unsigned base;
        base = wall_clock;
        if ($urandom_range(0, 7) == 0 && base > 0) req_value = base - 1;
        else req_value = base + $urandom_range(0, 3);
        for (int i = 0; i < NS; i++)
          strm_elapsed[i*W +: W] = base + $urandom_range(0, 6);
      end
    end
    @(negedge clk); #1;
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule